// File: doc/BRIEF.md
# Prioritized Interrupt Event Controller

This block gathers numbered interrupt events from the sound subsystem and drives one fast-interrupt request line toward an embedded processor. Each source signals with a single-cycle strobe. The block keeps a bitmap of the events that are waiting and a small register that holds the number of the event to serve. The processor reads that number from the bus.

The processor acknowledges events by writing to a clear register. Retirement is deliberately slow. A counter records each clear write, and only a fixed number of writes removes one event. The removed event is the lowest-numbered waiting one, and the number register then moves to the next waiting event above it. A write to the number register is accepted on the bus but changes nothing. After reset one event, the timer, is already waiting, so the request line starts asserted.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Synchronous active-high reset leaves only bit 2 of the bitmap set, the event number at 2, the request high and the clear-write counter at zero. A partial count made before reset does not carry over.
- R2: A strobe on `evt_stb[i]` sets bitmap bit i on the next clock. Every source strobed in the same cycle is recorded, and with no strobe and no clear write the bitmap holds.
- R3: The request output goes high on the clock after an event arrives into an empty bitmap. It goes low on the clock on which a retirement leaves the bitmap empty.
- R4: On arrival of one or more events, the event number becomes the smallest strobed number if the stored number is 0 or greater than that smallest number. Otherwise it keeps its value, even when that value names an event that is no longer waiting.
- R5: A clear write is `bus_wr` high with `bus_sel` = 0. The fourth such write retires one event and returns the counter to zero. The first three writes change neither the bitmap nor the event number.
- R6: A retirement clears the lowest set bit of the bitmap. It then loads the event number with the lowest bit still set, which lies above the cleared one. If no bit remains, the event number keeps its value.
- R7: Clear writes made while the bitmap is empty still advance and wrap the counter. They change no output.
- R8: When a strobe and a retiring clear write fall in the same cycle, the retirement is applied first. The new bit is then set, and the R4 comparison uses the number left by the retirement, so the event is not lost.
- R9: A bus write with `bus_sel` = 1 targets the event-number register. It changes no state and does not advance the clear counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_stb | input | 8 | One-cycle event strobes, bit i for event i |
| bus_wr | input | 1 | Bus write strobe |
| bus_sel | input | 1 | Register select for bus writes: 0 selects the clear register, 1 selects the event-number register |
| evt_num | output | 3 | Number of the event to serve, readable from the bus |
| irq | output | 1 | Fast-interrupt request |
| pending | output | 8 | Bitmap of waiting events |

## Verification
The bench builds the block with its default parameters: eight events, four clear writes per retirement and event 2 pending at reset. With these values a full walk runs from a bitmap holding several events down to an empty bitmap and back again in a few dozen cycles. The walk reaches the stale-number case, where a higher-numbered event arrives after the register was left pointing at an event already retired. It also reaches the case of event 0 reading as an empty register, and a counter that wraps while nothing is waiting.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int EVT_COUNT_DEF  = 8;
    localparam int CLR_WRITES_DEF = 4;
    localparam int BOOT_EVT_DEF   = 2;

    typedef enum logic {
        SEL_CLEAR  = 1'b0,
        SEL_NUMBER = 1'b1
    } bus_sel_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/evt_prio_find.sv
module evt_prio_find #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/evt_clear_div.sv
module evt_clear_div #(
    parameter int COUNT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic fire
);
    localparam int CW = evt_irq_pkg::idx_width(COUNT);
    localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

    logic [CW-1:0] cnt_q;

    assign fire = tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= fire ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/evt_retire.sv
module evt_retire #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  pend_i,
    input  logic [IW-1:0] num_i,
    output logic [W-1:0]  pend_o,
    output logic [IW-1:0] num_o
);
    logic [IW-1:0] lo_idx;
    logic          lo_found;
    logic [W-1:0]  stripped;
    logic [IW-1:0] nx_idx;
    logic          nx_found;

    evt_prio_find #(.W(W), .IW(IW)) u_lo (
        .vec   (pend_i),
        .idx   (lo_idx),
        .found (lo_found)
    );

    always_comb begin
        stripped = pend_i;
        if (lo_found) begin
            stripped[lo_idx] = 1'b0;
        end
    end

    evt_prio_find #(.W(W), .IW(IW)) u_next (
        .vec   (stripped),
        .idx   (nx_idx),
        .found (nx_found)
    );

    assign pend_o = stripped;
    assign num_o  = nx_found ? nx_idx : num_i;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
    parameter int NUM_EVT    = evt_irq_pkg::EVT_COUNT_DEF,
    parameter int CLR_WRITES = evt_irq_pkg::CLR_WRITES_DEF,
    parameter int BOOT_EVT   = evt_irq_pkg::BOOT_EVT_DEF,
    localparam int IW        = evt_irq_pkg::idx_width(NUM_EVT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_stb,
    input  logic               bus_wr,
    input  logic               bus_sel,
    output logic [IW-1:0]      evt_num,
    output logic               irq,
    output logic [NUM_EVT-1:0] pending
);
    import evt_irq_pkg::*;

    localparam logic [NUM_EVT-1:0] BOOT_PEND = NUM_EVT'(1) << BOOT_EVT;
    localparam logic [IW-1:0]      BOOT_NUM  = IW'(BOOT_EVT);

    logic [NUM_EVT-1:0] pend_q, pend_d, ret_pend, mid_pend;
    logic [IW-1:0]      num_q, num_d, ret_num, mid_num;
    logic               irq_q, irq_d;
    logic               clr_hit, retire;
    logic [IW-1:0]      stb_min;
    logic               stb_any;

    assign clr_hit = bus_wr && (bus_sel == SEL_CLEAR);

    evt_clear_div #(.COUNT(CLR_WRITES)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (clr_hit),
        .fire (retire)
    );

    evt_retire #(.W(NUM_EVT), .IW(IW)) u_ret (
        .pend_i (pend_q),
        .num_i  (num_q),
        .pend_o (ret_pend),
        .num_o  (ret_num)
    );

    evt_prio_find #(.W(NUM_EVT), .IW(IW)) u_stb (
        .vec   (evt_stb),
        .idx   (stb_min),
        .found (stb_any)
    );

    always_comb begin
        mid_pend = retire ? ret_pend : pend_q;
        mid_num  = retire ? ret_num  : num_q;
        pend_d   = mid_pend | evt_stb;
        num_d    = mid_num;
        irq_d    = irq_q;
        if (retire && (ret_pend == '0)) begin
            irq_d = 1'b0;
        end
        if (stb_any) begin
            if ((mid_num == '0) || (stb_min < mid_num)) begin
                num_d = stb_min;
            end
            if (mid_pend == '0) begin
                irq_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= BOOT_PEND;
            num_q  <= BOOT_NUM;
            irq_q  <= 1'b1;
        end else begin
            pend_q <= pend_d;
            num_q  <= num_d;
            irq_q  <= irq_d;
        end
    end

    assign pending = pend_q;
    assign evt_num = num_q;
    assign irq     = irq_q;
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic [W-1:0]  evt_stb,
    input logic          bus_wr,
    input logic          bus_sel,
    input logic [IW-1:0] evt_num,
    input logic          irq,
    input logic [W-1:0]  pending
);
    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    a_r3_irq_follows_bitmap: assert property (@(posedge clk) disable iff (rst || !seen)
        irq == (pending != '0));

    a_r2_strobe_recorded: assert property (@(posedge clk) disable iff (rst || !seen)
        (evt_stb != '0) |=> ((pending & $past(evt_stb)) == $past(evt_stb)));

    a_r5_no_clear_no_retire: assert property (@(posedge clk) disable iff (rst || !seen)
        !(bus_wr && !bus_sel) |=> (($past(pending) & ~pending) == '0));

    a_r6_one_retire_at_most: assert property (@(posedge clk) disable iff (rst || !seen)
        (bus_wr && !bus_sel) |=> ($countones($past(pending) & ~pending) <= 1));

    a_r9_quiet_holds: assert property (@(posedge clk) disable iff (rst || !seen)
        ((evt_stb == '0) && !(bus_wr && !bus_sel)) |=> ($stable(evt_num) && $stable(pending)));
endmodule

bind evt_irq_ctrl evt_irq_chk #(.W(NUM_EVT), .IW(IW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .evt_stb (evt_stb),
    .bus_wr  (bus_wr),
    .bus_sel (bus_sel),
    .evt_num (evt_num),
    .irq     (irq),
    .pending (pending)
);

// File: tb/sim_evt_irq_ctrl.sv
module sim_evt_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] evt_stb = '0;
    logic       bus_wr = 1'b0;
    logic       bus_sel = 1'b0;
    logic [2:0] evt_num;
    logic       irq;
    logic [7:0] pending;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    evt_irq_ctrl u0 (
        .clk(clk), .rst(rst), .evt_stb(evt_stb), .bus_wr(bus_wr),
        .bus_sel(bus_sel), .evt_num(evt_num), .irq(irq), .pending(pending)
    );

    // {stb, wr, sel, reps, exp pending, exp num, exp irq, tag}
    localparam int NV = 23;
    localparam logic [29:0] VEC [NV] = '{
        {8'h20, 1'b0, 1'b0, 4'd1, 8'h24, 3'd2, 1'b1, 4'd4},
        {8'h01, 1'b0, 1'b0, 4'd1, 8'h25, 3'd0, 1'b1, 4'd4},
        {8'h00, 1'b1, 1'b0, 4'd1, 8'h25, 3'd0, 1'b1, 4'd5},
        {8'h00, 1'b1, 1'b1, 4'd1, 8'h25, 3'd0, 1'b1, 4'd9},
        {8'h00, 1'b1, 1'b0, 4'd2, 8'h25, 3'd0, 1'b1, 4'd5},
        {8'h00, 1'b1, 1'b0, 4'd1, 8'h24, 3'd2, 1'b1, 4'd6},
        {8'h08, 1'b0, 1'b0, 4'd1, 8'h2C, 3'd2, 1'b1, 4'd4},
        {8'h00, 1'b1, 1'b0, 4'd3, 8'h2C, 3'd2, 1'b1, 4'd5},
        {8'h00, 1'b1, 1'b0, 4'd1, 8'h28, 3'd3, 1'b1, 4'd6},
        {8'h00, 1'b1, 1'b0, 4'd4, 8'h20, 3'd5, 1'b1, 4'd6},
        {8'h12, 1'b0, 1'b0, 4'd1, 8'h32, 3'd1, 1'b1, 4'd2},
        {8'h00, 1'b1, 1'b0, 4'd3, 8'h32, 3'd1, 1'b1, 4'd5},
        {8'h40, 1'b1, 1'b0, 4'd1, 8'h70, 3'd4, 1'b1, 4'd8},
        {8'h00, 1'b1, 1'b0, 4'd4, 8'h60, 3'd5, 1'b1, 4'd6},
        {8'h00, 1'b1, 1'b0, 4'd4, 8'h40, 3'd6, 1'b1, 4'd6},
        {8'h00, 1'b1, 1'b0, 4'd4, 8'h00, 3'd6, 1'b0, 4'd3},
        {8'h80, 1'b0, 1'b0, 4'd1, 8'h80, 3'd6, 1'b1, 4'd3},
        {8'h00, 1'b1, 1'b0, 4'd4, 8'h00, 3'd6, 1'b0, 4'd3},
        {8'h00, 1'b1, 1'b0, 4'd4, 8'h00, 3'd6, 1'b0, 4'd7},
        {8'h01, 1'b0, 1'b0, 4'd1, 8'h01, 3'd0, 1'b1, 4'd4},
        {8'h04, 1'b0, 1'b0, 4'd1, 8'h05, 3'd2, 1'b1, 4'd4},
        {8'h00, 1'b1, 1'b0, 4'd4, 8'h04, 3'd2, 1'b1, 4'd6},
        {8'h00, 1'b0, 1'b0, 4'd5, 8'h04, 3'd2, 1'b1, 4'd2}
    };

    function automatic string rtag(input logic [3:0] n);
        case (n)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] ep, input logic [2:0] en, input logic ei);
        n_chk++;
        if (pending !== ep || evt_num !== en || irq !== ei) begin
            n_bad++;
            $display("FAIL %s: pending=%h num=%0d irq=%b expected pending=%h num=%0d irq=%b",
                     tag, pending, evt_num, irq, ep, en, ei);
        end
    endtask

    task automatic step(input logic [7:0] s, input logic w, input logic sel);
        evt_stb = s;
        bus_wr  = w;
        bus_sel = sel;
        @(negedge clk);
        evt_stb = '0;
        bus_wr  = 1'b0;
        bus_sel = 1'b0;
    endtask

    task automatic clears(input int n);
        for (int k = 0; k < n; k++) step(8'h00, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1", 8'h04, 3'd2, 1'b1);

        for (int v = 0; v < NV; v++) begin
            for (int r = 0; r < int'(VEC[v][19:16]); r++)
                step(VEC[v][29:22], VEC[v][21], VEC[v][20]);
            check(rtag(VEC[v][3:0]), VEC[v][15:8], VEC[v][7:5], VEC[v][4]);
        end

        // R1: partial count is dropped by reset
        clears(3);
        check("R5", 8'h04, 3'd2, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", 8'h04, 3'd2, 1'b1);
        clears(3);
        check("R1", 8'h04, 3'd2, 1'b1);
        clears(1);
        check("R3", 8'h00, 3'd2, 1'b0);

        // R8: retirement empties the bitmap while a new event arrives
        step(8'h08, 1'b0, 1'b0);
        check("R4", 8'h08, 3'd2, 1'b1);
        clears(3);
        step(8'h20, 1'b1, 1'b0);
        check("R8", 8'h20, 3'd2, 1'b1);

        // R9: a number-register write is not counted as a clear
        step(8'h00, 1'b1, 1'b1);
        check("R9", 8'h20, 3'd2, 1'b1);
        clears(3);
        check("R9", 8'h20, 3'd2, 1'b1);
        clears(1);
        check("R6", 8'h00, 3'd2, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule